// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block holds a small set of control and status registers for a workstation I/O controller. A simple register bus reaches them, with byte, halfword and word accesses. Each register has its own region code. Each region accepts exactly one access size, and only at offset 0. A write of any other shape is dropped, and a read of any other shape returns zero.

Beside plain storage, the block turns certain register writes into one-cycle pulses on its outputs: a floppy terminal-count strobe, a power-off request and a system reset request. It also keeps a power-fail status bit. That bit is fed from a synchronized input and gated by an enable bit. Software can clear it through a write-one-to-clear bit, and it drives a level interrupt. A synchronous reset clears the volatile registers. It leaves the diagnostic byte, the LED halfword and the system control byte untouched, so a reset-status flag set before a software reset can still be read after it.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Region codes are config=0, diagnostic=1, modem=2, aux1=3, aux2=4, LED=5, system=6; code 7 selects nothing. Config, diagnostic and modem store all 8 written bits and read them back unchanged, in bits 7:0 of `rd_data` with zeros above.
- R2: Size codes are byte=0, halfword=1, word=2, reserved=3. Regions 0-4 take only byte accesses, LED takes only halfword, system takes only word, and every region requires offset 0. Any other access leaves every register and every output unchanged on write and reads as 0.
- R3: An accepted aux1 write with data bit 1 set raises `tc_pulse`. Aux1 stores the written byte with bit 1 forced to 0, so that bit always reads back as 0.
- R4: An accepted aux2 write keeps only data bits 0 and 1 and preserves the power-fail status (aux2 bit 5). If data bit 1 is 1, the status bit is cleared. Bit 1 always reads back as 0, and bits 7:6 and 4:2 read as 0.
- R5: An accepted aux2 write with data bit 0 set raises `pwroff_req`, and bit 0 stays set in aux2 until the next aux2 write.
- R6: `pwr_fail_in` passes through two flip-flops. On each change of the synchronized level, aux2 bit 5 becomes 1 if the level is 1 and config bit 3 is 1; otherwise it becomes 0. While the level is steady, the bit keeps its value.
- R7: `pf_irq` is high exactly when aux2 bit 5 and config bit 3 are both 1. Clearing config bit 3 lowers the interrupt but does not clear the status bit.
- R8: An accepted system write with data bit 0 set loads the system register with 0x02 and raises `sysrst_req`. An accepted system write with bit 0 clear changes nothing.
- R9: The LED register stores and returns a full 16-bit halfword.
- R10: Reset clears config, modem, aux1, aux2, the synchronizer and all pulse outputs. It keeps the diagnostic, LED and system registers.
- R11: `tc_pulse`, `pwroff_req` and `sysrst_req` are high for exactly the one clock cycle that follows the clock edge accepting the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access qualifier for writes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 3 | Region code (see R1) |
| req_offset | input | 2 | Byte offset inside the region |
| req_size | input | 2 | Access size code (see R2) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for the addressed region |
| pwr_fail_in | input | 1 | Asynchronous power-fail indication |
| pf_irq | output | 1 | Power-fail interrupt level |
| tc_pulse | output | 1 | One-cycle floppy terminal-count strobe |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps all 256 byte values through every byte register and checks each value against its own masking rule. A design that stored the aux1 strobe bit would read it back as set. A design that let aux2 data bits other than 0 and 1 through would return stray bits. It then tries every illegal size and offset on every region: a loose decoder would corrupt a stored pattern, return non-zero read data, or fire a strobe. The power-fail sequence first sets the status bit. It then checks that masking the enable keeps the status and lowers only the interrupt, that clear-on-write wins over a steady input, and that a falling input clears the status. Reset retention is checked by writing every register before a reset and reading all of them after it.

// File: rtl/aux_pkg.sv
package aux_pkg;

    localparam int BYTE_W      = 8;
    localparam int LED_W       = 16;
    localparam int WORD_W      = 32;
    localparam int OFF_W       = 2;
    localparam int NUM_REGIONS = 8;

    localparam int CFG_PFEN_BIT = 3;
    localparam int AUX1_TC_BIT  = 1;
    localparam int AUX2_OFF_BIT = 0;
    localparam int AUX2_CLR_BIT = 1;
    localparam int AUX2_PF_BIT  = 5;
    localparam int SYS_RST_BIT  = 0;

    localparam logic [BYTE_W-1:0] SYS_RST_FLAG = 8'h02;

    typedef enum logic [2:0] {
        RG_CFG   = 3'd0,
        RG_DIAG  = 3'd1,
        RG_MODEM = 3'd2,
        RG_AUX1  = 3'd3,
        RG_AUX2  = 3'd4,
        RG_LED   = 3'd5,
        RG_SYS   = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] diag;
        logic [BYTE_W-1:0] modem;
        logic [BYTE_W-1:0] aux1;
        logic [BYTE_W-1:0] aux2;
        logic [BYTE_W-1:0] sys;
        logic [LED_W-1:0]  led;
    } state_t;

    // Access size each region accepts; RSVD means the region takes no access.
    function automatic size_e region_size(input region_e r);
        case (r)
            RG_CFG, RG_DIAG, RG_MODEM, RG_AUX1, RG_AUX2: return SZ_BYTE;
            RG_LED:                                      return SZ_HALF;
            RG_SYS:                                      return SZ_WORD;
            default:                                     return SZ_RSVD;
        endcase
    endfunction

    // New aux2 contents from the two writable data bits and the current status.
    function automatic logic [BYTE_W-1:0] aux2_merge(input logic [1:0] wbits,
                                                    input logic pf_now);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[AUX2_OFF_BIT] = wbits[AUX2_OFF_BIT];
        r[AUX2_PF_BIT]  = pf_now & ~wbits[AUX2_CLR_BIT];
        return r;
    endfunction

    // The strobe bit never lands in storage.
    function automatic logic [BYTE_W-1:0] aux1_store(input logic [BYTE_W-1:0] w);
        logic [BYTE_W-1:0] r;
        r = w;
        r[AUX1_TC_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode
    import aux_pkg::*;
#(
    parameter int NREG = NUM_REGIONS,
    parameter int OW   = OFF_W
) (
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [2:0]      req_region,
    input  logic [OW-1:0]   req_offset,
    input  logic [1:0]      req_size,
    output logic            acc_legal,
    output logic [NREG-1:0] wr_en
);

    region_e region;
    size_e   size;

    assign region    = region_e'(req_region);
    assign size      = size_e'(req_size);
    assign acc_legal = (region_size(region) != SZ_RSVD) &&
                       (region_size(region) == size) &&
                       (req_offset == '0);

    for (genvar i = 0; i < NREG; i++) begin : g_wr
        assign wr_en[i] = req_valid && req_write && acc_legal &&
                          (req_region == 3'(i));
    end

endmodule

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic changed
);

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_in};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level   = sh_q[STAGES-1];
    assign changed = sh_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/aux_reg_file.sv
module aux_reg_file
    import aux_pkg::*;
#(
    parameter int NREG = NUM_REGIONS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  wr_en,
    input  logic [LED_W-1:0] wdata,
    input  logic             pf_level,
    input  logic             pf_changed,
    output state_t           st,
    output logic             tc_pulse,
    output logic             pwroff_req,
    output logic             sysrst_req
);

    logic [BYTE_W-1:0] cfg_q, modem_q, aux1_q, aux2_q;
    logic [BYTE_W-1:0] diag_q, sys_q;
    logic [LED_W-1:0]  led_q;
    logic              tc_q, off_q, srst_q;
    logic              pf_now;

    // Status after a possible input change, before any aux2 write is merged.
    assign pf_now = pf_changed ? (pf_level & cfg_q[CFG_PFEN_BIT])
                               : aux2_q[AUX2_PF_BIT];

    // Volatile state: cleared by reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            modem_q <= '0;
            aux1_q  <= '0;
            aux2_q  <= '0;
            tc_q    <= 1'b0;
            off_q   <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            if (wr_en[RG_CFG])   cfg_q   <= wdata[BYTE_W-1:0];
            if (wr_en[RG_MODEM]) modem_q <= wdata[BYTE_W-1:0];
            if (wr_en[RG_AUX1])  aux1_q  <= aux1_store(wdata[BYTE_W-1:0]);
            if (wr_en[RG_AUX2])
                aux2_q <= aux2_merge(wdata[1:0], pf_now);
            else
                aux2_q[AUX2_PF_BIT] <= pf_now;
            tc_q   <= wr_en[RG_AUX1] && wdata[AUX1_TC_BIT];
            off_q  <= wr_en[RG_AUX2] && wdata[AUX2_OFF_BIT];
            srst_q <= wr_en[RG_SYS]  && wdata[SYS_RST_BIT];
        end
    end

    // Retained state: reset has no effect.
    always_ff @(posedge clk) begin
        if (wr_en[RG_DIAG]) diag_q <= wdata[BYTE_W-1:0];
        if (wr_en[RG_LED])  led_q  <= wdata;
        if (wr_en[RG_SYS] && wdata[SYS_RST_BIT]) sys_q <= SYS_RST_FLAG;
    end

    always_comb begin
        st.cfg   = cfg_q;
        st.diag  = diag_q;
        st.modem = modem_q;
        st.aux1  = aux1_q;
        st.aux2  = aux2_q;
        st.sys   = sys_q;
        st.led   = led_q;
    end

    assign tc_pulse   = tc_q;
    assign pwroff_req = off_q;
    assign sysrst_req = srst_q;

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_region,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pwr_fail_in,
    output logic              pf_irq,
    output logic              tc_pulse,
    output logic              pwroff_req,
    output logic              sysrst_req
);

    logic                   acc_legal;
    logic [NUM_REGIONS-1:0] wr_en;
    logic                   pf_level, pf_changed;
    state_t                 st;
    logic                   unused_hi;

    assign unused_hi = ^req_wdata[WORD_W-1:LED_W];

    aux_bus_decode #(.NREG(NUM_REGIONS), .OW(OFF_W)) u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_region (req_region),
        .req_offset (req_offset),
        .req_size   (req_size),
        .acc_legal  (acc_legal),
        .wr_en      (wr_en)
    );

    aux_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pwr_fail_in),
        .level    (pf_level),
        .changed  (pf_changed)
    );

    aux_reg_file #(.NREG(NUM_REGIONS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wdata      (req_wdata[LED_W-1:0]),
        .pf_level   (pf_level),
        .pf_changed (pf_changed),
        .st         (st),
        .tc_pulse   (tc_pulse),
        .pwroff_req (pwroff_req),
        .sysrst_req (sysrst_req)
    );

    always_comb begin
        rd_data = '0;
        if (acc_legal) begin
            case (region_e'(req_region))
                RG_CFG:   rd_data[BYTE_W-1:0] = st.cfg;
                RG_DIAG:  rd_data[BYTE_W-1:0] = st.diag;
                RG_MODEM: rd_data[BYTE_W-1:0] = st.modem;
                RG_AUX1:  rd_data[BYTE_W-1:0] = st.aux1;
                RG_AUX2:  rd_data[BYTE_W-1:0] = st.aux2;
                RG_LED:   rd_data[LED_W-1:0]  = st.led;
                RG_SYS:   rd_data[BYTE_W-1:0] = st.sys;
                default:  rd_data = '0;
            endcase
        end
    end

    assign pf_irq = st.aux2[AUX2_PF_BIT] & st.cfg[CFG_PFEN_BIT];

endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
    import aux_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [WORD_W-1:0]      req_wdata,
    input logic [NUM_REGIONS-1:0] wr_en,
    input state_t                 st,
    input logic                   pf_irq,
    input logic                   tc_pulse,
    input logic                   pwroff_req,
    input logic                   sysrst_req
);

    // R3
    tc_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en[RG_AUX1] && req_wdata[AUX1_TC_BIT]) |=> tc_pulse);

    // R11
    tc_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> $past(wr_en[RG_AUX1] && req_wdata[AUX1_TC_BIT]));

    // R3
    aux1_strobe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en[RG_AUX1] |=> !st.aux1[AUX1_TC_BIT]);

    // R5
    pwroff_origin_chk: assert property (@(posedge clk) disable iff (rst)
        pwroff_req |-> $past(wr_en[RG_AUX2] && req_wdata[AUX2_OFF_BIT]));

    // R4
    aux2_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en[RG_AUX2] && req_wdata[AUX2_CLR_BIT]) |=> (!st.aux2[AUX2_PF_BIT] && !pf_irq));

    // R8
    sysrst_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en[RG_SYS] && req_wdata[SYS_RST_BIT]) |=> (sysrst_req && st.sys == SYS_RST_FLAG));

    // R6
    pf_set_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.aux2[AUX2_PF_BIT]) |-> $past(st.cfg[CFG_PFEN_BIT]));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !st.cfg[CFG_PFEN_BIT] |-> !pf_irq);

endmodule

bind aux_sysctl_regs aux_sysctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_wdata  (req_wdata),
    .wr_en      (wr_en),
    .st         (st),
    .pf_irq     (pf_irq),
    .tc_pulse   (tc_pulse),
    .pwroff_req (pwroff_req),
    .sysrst_req (sysrst_req)
);

// File: tb/aux_sysctl_regs_bench.sv
module aux_sysctl_regs_bench;

    localparam logic [2:0] CFG = 3'd0, DIAG = 3'd1, MODEM = 3'd2, AUX1 = 3'd3,
                           AUX2 = 3'd4, LED = 3'd5, SYS = 3'd6, NONE = 3'd7;
    localparam logic [1:0] BY = 2'd0, HW = 2'd1, WD = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_region = 3'd0;
    logic [1:0]  req_offset = 2'd0, req_size = 2'd0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        pwr_fail_in = 1'b0;
    logic        pf_irq, tc_pulse, pwroff_req, sysrst_req;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    aux_sysctl_regs u_aux_sysctl_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_region(req_region), .req_offset(req_offset), .req_size(req_size),
        .req_wdata(req_wdata), .rd_data(rd_data), .pwr_fail_in(pwr_fail_in),
        .pf_irq(pf_irq), .tc_pulse(tc_pulse), .pwroff_req(pwroff_req),
        .sysrst_req(sysrst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] r, input logic [1:0] off, input logic [1:0] sz,
                      input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_region = r; req_offset = off; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] r, input logic [1:0] off, input logic [1:0] sz,
                      output logic [31:0] d);
        req_region = r; req_offset = off; req_size = sz;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    function automatic logic [1:0] legal_size(input logic [2:0] r);
        return (r == LED) ? HW : (r == SYS) ? WD : BY;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=done", total);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R10 reset state of the volatile registers and outputs
        rd(CFG, 0, BY, d);   chk("R10 cfg after reset", d, 0);
        rd(MODEM, 0, BY, d); chk("R10 modem after reset", d, 0);
        rd(AUX1, 0, BY, d);  chk("R10 aux1 after reset", d, 0);
        rd(AUX2, 0, BY, d);  chk("R10 aux2 after reset", d, 0);
        chk("R10 outputs after reset", {28'd0, pf_irq, tc_pulse, pwroff_req, sysrst_req}, 0);

        // R1 full byte sweep on plain registers
        for (int r = 0; r < 3; r++)
            for (int v = 0; v < 256; v++) begin
                wr(3'(r), 0, BY, {24'hABCDEF, 8'(v)});
                rd(3'(r), 0, BY, d);
                chk("R1 byte readback", d, {24'd0, 8'(v)});
            end

        // R3 / R11 aux1 sweep
        for (int v = 0; v < 256; v++) begin
            wr(AUX1, 0, BY, 32'(v));
            chk("R3 tc pulse", {31'd0, tc_pulse}, {31'd0, 1'(v >> 1)});
            rd(AUX1, 0, BY, d);
            chk("R3 aux1 readback", d, 32'(v & 8'hFD));
            @(negedge clk);
            chk("R11 tc one cycle", {31'd0, tc_pulse}, 0);
        end

        // R4 / R5 aux2 sweep with status clear
        for (int v = 0; v < 256; v++) begin
            wr(AUX2, 0, BY, 32'(v));
            chk("R5 pwroff pulse", {31'd0, pwroff_req}, {31'd0, 1'(v & 1)});
            rd(AUX2, 0, BY, d);
            chk("R4 aux2 readback", d, 32'(v & 1));
            @(negedge clk);
            chk("R11 pwroff one cycle", {31'd0, pwroff_req}, 0);
        end

        // R9 LED halfword
        wr(LED, 0, HW, 32'hFFFF_0000); rd(LED, 0, HW, d); chk("R9 led 0000", d, 32'h0000);
        wr(LED, 0, HW, 32'h0000_FFFF); rd(LED, 0, HW, d); chk("R9 led ffff", d, 32'hFFFF);
        wr(LED, 0, HW, 32'h9999_1234); rd(LED, 0, HW, d); chk("R9 led 1234", d, 32'h1234);

        // R8 system control
        wr(SYS, 0, WD, 32'h0000_0001);
        chk("R8 sysrst pulse", {31'd0, sysrst_req}, 1);
        rd(SYS, 0, WD, d); chk("R8 sys flag", d, 32'h02);
        @(negedge clk); chk("R11 sysrst one cycle", {31'd0, sysrst_req}, 0);
        wr(SYS, 0, WD, 32'hFFFF_FFFE);
        chk("R8 no pulse without bit0", {31'd0, sysrst_req}, 0);
        rd(SYS, 0, WD, d); chk("R8 sys unchanged", d, 32'h02);

        // R2 illegal size/offset sweep on storing regions
        wr(CFG, 0, BY, 32'hA5); wr(DIAG, 0, BY, 32'hA5); wr(MODEM, 0, BY, 32'hA5);
        wr(LED, 0, HW, 32'h5AA5); wr(AUX1, 0, BY, 32'h00); wr(AUX2, 0, BY, 32'h00);
        for (int r = 0; r < 8; r++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++) begin
                    if (r != 7 && s == int'(legal_size(3'(r))) && o == 0) continue;
                    wr(3'(r), 2'(o), 2'(s), 32'hFFFF_FFFF);
                    chk("R2 no pulse on illegal", {29'd0, tc_pulse, pwroff_req, sysrst_req}, 0);
                    rd(3'(r), 2'(o), 2'(s), d);
                    chk("R2 illegal read zero", d, 0);
                end
        rd(CFG, 0, BY, d);   chk("R2 cfg kept", d, 32'hA5);
        rd(DIAG, 0, BY, d);  chk("R2 diag kept", d, 32'hA5);
        rd(MODEM, 0, BY, d); chk("R2 modem kept", d, 32'hA5);
        rd(LED, 0, HW, d);   chk("R2 led kept", d, 32'h5AA5);
        rd(AUX1, 0, BY, d);  chk("R2 aux1 kept", d, 0);
        rd(AUX2, 0, BY, d);  chk("R2 aux2 kept", d, 0);
        rd(SYS, 0, WD, d);   chk("R2 sys kept", d, 32'h02);

        // R10 retention across reset
        wr(DIAG, 0, BY, 32'h5C); wr(LED, 0, HW, 32'hBEEF);
        wr(CFG, 0, BY, 32'h3C); wr(MODEM, 0, BY, 32'h77); wr(AUX1, 0, BY, 32'h81);
        wr(AUX2, 0, BY, 32'h01);
        do_reset();
        rd(DIAG, 0, BY, d);  chk("R10 diag kept", d, 32'h5C);
        rd(LED, 0, HW, d);   chk("R10 led kept", d, 32'hBEEF);
        rd(SYS, 0, WD, d);   chk("R10 sys flag kept", d, 32'h02);
        rd(CFG, 0, BY, d);   chk("R10 cfg cleared", d, 0);
        rd(MODEM, 0, BY, d); chk("R10 modem cleared", d, 0);
        rd(AUX1, 0, BY, d);  chk("R10 aux1 cleared", d, 0);
        rd(AUX2, 0, BY, d);  chk("R10 aux2 cleared", d, 0);

        // R6 / R7 / R4 power-fail sequence
        wr(CFG, 0, BY, 32'h08);
        pwr_fail_in = 1'b1; idle(4);
        rd(AUX2, 0, BY, d); chk("R6 status set", d, 32'h20);
        chk("R7 irq high", {31'd0, pf_irq}, 1);
        wr(CFG, 0, BY, 32'h00);
        chk("R7 irq masked", {31'd0, pf_irq}, 0);
        rd(AUX2, 0, BY, d); chk("R7 status kept when masked", d, 32'h20);
        wr(CFG, 0, BY, 32'h08);
        chk("R7 irq back", {31'd0, pf_irq}, 1);
        wr(AUX2, 0, BY, 32'h01);
        chk("R5 pwroff with status", {31'd0, pwroff_req}, 1);
        rd(AUX2, 0, BY, d); chk("R4 status preserved", d, 32'h21);
        wr(AUX2, 0, BY, 32'h02);
        rd(AUX2, 0, BY, d); chk("R4 clear wins", d, 0);
        chk("R7 irq after clear", {31'd0, pf_irq}, 0);
        idle(4);
        rd(AUX2, 0, BY, d); chk("R6 steady input no reset", d, 0);
        pwr_fail_in = 1'b0; idle(4);
        pwr_fail_in = 1'b1; idle(4);
        rd(AUX2, 0, BY, d); chk("R6 set again", d, 32'h20);
        pwr_fail_in = 1'b0; idle(4);
        rd(AUX2, 0, BY, d); chk("R6 fall clears", d, 0);
        wr(CFG, 0, BY, 32'h00);
        pwr_fail_in = 1'b1; idle(4);
        rd(AUX2, 0, BY, d); chk("R6 gated by enable", d, 0);
        wr(CFG, 0, BY, 32'h08);
        chk("R7 no irq without status", {31'd0, pf_irq}, 0);
        pwr_fail_in = 1'b0; idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule